// File: doc/BRIEF.md
# Branch Special-Register Bank Access Decoder

This block looks at one 32-bit branch instruction and works out how it uses a special-register store that is split into two banks. The even bank holds the link and target registers. The odd bank holds the count register. For each issue the block produces a read index for each bank, a flag that picks the odd bank as the indirect target source, one write index shared by both banks, a write enable for each bank, a count-decrement flag and a static taken prediction.

The count register and the link register sit in opposite banks, and they share the same index. So one issue can read and decrement the count while it also reads or writes the link register. No branch needs a second pass through the pipe.

The outputs are registered by default, with one cycle of latency. A parameter can make the block purely combinational instead. Any word that is not one of the recognised branch forms gives idle outputs. A low valid input also gives idle outputs. The idle value of every output is zero.

Top module: `brspr_access_decode`

## Requirements
- R1: The link register is even-bank index 5 and the target register is even-bank index 6. The count register is odd-bank index 5, which is the same value as the link index.
- R2: Bits 31:26 hold the major opcode. Major opcode 16 is a relative conditional branch and 18 is an unconditional branch. Major opcode 19 with bits 10:1 equal to 16, 528 or 560 is an indirect conditional branch through link, count or target respectively.
- R3: The count is decremented only when bit 23 is 0 and the instruction is either a relative conditional branch or an indirect branch through link or target. The indirect branch through count never decrements.
- R4: When the count is decremented, the odd read index and the write index both equal the count index, and the odd write enable is 1.
- R5: For any recognised branch with bit 0 set, the write index is the link index and the even write enable is 1. This can happen in the same issue as a count write.
- R6: Each indirect form reads its target from a set place. The link form reads the even bank at the link index. The count form reads the odd bank at the count index and sets the odd-read-select flag. The target form reads the even bank at the target index.
- R7: For a relative conditional branch, the prediction equals bit 15. An unconditional branch is always predicted taken. Indirect branches are predicted not taken.
- R8: Any other opcode, and any other bits 10:1 value under opcode 19, gives all outputs 0. This holds whatever bits 23, 15 and 0 are.
- R9: When valid is low, all outputs are 0, even if the word is a branch.
- R10: With the output register enabled, the outputs follow the inputs one clock later. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Qualifies insn_in |
| insn_in | input | 32 | Instruction word |
| even_rd_idx | output | 3 | Even-bank read index |
| odd_rd_idx | output | 3 | Odd-bank read index |
| odd_rd_sel | output | 1 | Indirect target comes from the odd bank |
| wr_idx | output | 3 | Write index shared by both banks |
| even_wr_en | output | 1 | Even-bank write enable |
| odd_wr_en | output | 1 | Odd-bank write enable |
| count_dec | output | 1 | Count register is decremented |
| pred_taken | output | 1 | Static taken prediction |

## Verification
The bench targets four corner cases:

- **Indirect branch through count with bit 23 clear.** A decoder that tested only bit 23 would raise a count write here and clobber the branch target.
- **Link-setting conditional branches that also decrement.** A design that lets the link write win over the count write would drop one of the two enables. A design that splits the write index would no longer point at the shared index.
- **Non-branch words and opcode 19 words with other extended codes.** These are driven with bits 0, 15 and 23 set, to catch a design that leaks writes or predictions from stray bits.
- **Low valid, and a reset in mid-stream.** A design that fails to gate or clear its outputs would show a stale branch decode.

// File: rtl/brs_pkg.sv
// Package: shared constants and the branch-kind type for the branch
// special-register bank access decoder.
// Assumes the usual 32-bit branch word layout with bit 0 as the LSB.
package brs_pkg;

    localparam int OPC_HI   = 31;
    localparam int OPC_LO   = 26;
    localparam int XO_HI    = 10;
    localparam int XO_LO    = 1;
    localparam int BIT_LINK = 0;
    localparam int BIT_BO2  = 23;
    localparam int BIT_HINT = 15;
    localparam int BIT_SEL_A = 10;   // 0: through link
    localparam int BIT_SEL_B = 6;    // with SEL_A=1: 0 count, 1 target

    localparam logic [5:0] OPC_REL    = 6'd16;
    localparam logic [5:0] OPC_UNCOND = 6'd18;
    localparam logic [5:0] OPC_EXT    = 6'd19;

    localparam logic [9:0] XO_VIA_LINK   = 10'd16;
    localparam logic [9:0] XO_VIA_COUNT  = 10'd528;
    localparam logic [9:0] XO_VIA_TARGET = 10'd560;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_REL,
        BK_UNCOND,
        BK_VIA_LINK,
        BK_VIA_COUNT,
        BK_VIA_TARGET
    } br_kind_e;

endpackage

// File: rtl/brs_classify.sv
// Module: brs_classify
// Sorts an instruction word into one of the branch kinds the decoder
// handles (R2). Anything else is BK_NONE.
// Assumes: pure combinational, no qualification by valid here.
module brs_classify
    import brs_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output br_kind_e          kind
);

    logic [OPC_HI-OPC_LO:0] opc;
    logic [XO_HI-XO_LO:0]   xo;

    assign opc = insn[OPC_HI:OPC_LO];
    assign xo  = insn[XO_HI:XO_LO];

    // Purpose: map the major and extended opcode to a branch kind (R2).
    always_comb begin
        kind = BK_NONE;
        case (opc)
            OPC_REL:    kind = BK_REL;
            OPC_UNCOND: kind = BK_UNCOND;
            OPC_EXT: begin
                case (xo)
                    XO_VIA_LINK:   kind = BK_VIA_LINK;
                    XO_VIA_COUNT:  kind = BK_VIA_COUNT;
                    XO_VIA_TARGET: kind = BK_VIA_TARGET;
                    default:       kind = BK_NONE;
                endcase
            end
            default: kind = BK_NONE;
        endcase
    end

endmodule

// File: rtl/brs_route.sv
// Module: brs_route
// Turns a branch kind and a few instruction bits into bank read and
// write controls. It places link and target in the even bank and count
// in the odd bank (R1).
// Assumes: the link and count indices are equal, so one shared write
// index serves both banks. This holds by deriving the count index from
// the link index.
module brs_route
    import brs_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int LINK_IDX   = 5,
    parameter int TARGET_IDX = 6
) (
    input  logic             valid,
    input  br_kind_e         kind,
    input  logic             bo2_bit,
    input  logic             link_bit,
    input  logic             hint_bit,
    output logic [IDX_W-1:0] even_rd,
    output logic [IDX_W-1:0] odd_rd,
    output logic             odd_sel,
    output logic [IDX_W-1:0] wr,
    output logic             even_we,
    output logic             odd_we,
    output logic             dec,
    output logic             pred
);

    localparam int COUNT_IDX = LINK_IDX;
    localparam logic [IDX_W-1:0] L_IDX = IDX_W'(LINK_IDX);
    localparam logic [IDX_W-1:0] C_IDX = IDX_W'(COUNT_IDX);
    localparam logic [IDX_W-1:0] T_IDX = IDX_W'(TARGET_IDX);

    logic is_branch;
    logic may_dec;

    // Purpose: flag the kinds that may use the count as a loop counter (R3).
    always_comb begin
        is_branch = (kind != BK_NONE);
        may_dec   = (kind == BK_REL) || (kind == BK_VIA_LINK) ||
                    (kind == BK_VIA_TARGET);
    end

    // Purpose: build all bank controls; idle when invalid (R3-R9).
    always_comb begin
        even_rd = '0;
        odd_rd  = '0;
        odd_sel = 1'b0;
        wr      = '0;
        even_we = 1'b0;
        odd_we  = 1'b0;
        dec     = 1'b0;
        pred    = 1'b0;
        if (valid && is_branch) begin
            dec = may_dec && !bo2_bit;
            if (dec) begin
                odd_rd = C_IDX;
                wr     = C_IDX;
                odd_we = 1'b1;
            end
            if (link_bit) begin
                wr      = L_IDX;
                even_we = 1'b1;
            end
            case (kind)
                BK_VIA_LINK:   even_rd = L_IDX;
                BK_VIA_TARGET: even_rd = T_IDX;
                BK_VIA_COUNT: begin
                    odd_rd  = C_IDX;
                    odd_sel = 1'b1;
                end
                default: ;
            endcase
            case (kind)
                BK_REL:    pred = hint_bit;
                BK_UNCOND: pred = 1'b1;
                default:   pred = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/brs_hold.sv
// Module: brs_hold
// Optional output stage. It is either a register with synchronous
// active-low clear, or a plain wire (R10).
// Assumes: the clear value of every output bit is zero.
module brs_hold #(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REGISTERED) begin : g_reg
            // Purpose: capture the decode once per clock, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/brspr_access_decode.sv
// Module: brspr_access_decode (top)
// Decodes a branch word into even/odd special-register bank access
// controls, a count-decrement flag and a static prediction.
// Assumes: link and count share one index. With OUT_REG=1, the outputs
// appear one clock after the inputs.
module brspr_access_decode
    import brs_pkg::*;
#(
    parameter int INSN_W     = 32,
    parameter int IDX_W      = 3,
    parameter int LINK_IDX   = 5,
    parameter int TARGET_IDX = 6,
    parameter bit OUT_REG    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [INSN_W-1:0] insn_in,
    output logic [IDX_W-1:0] even_rd_idx,
    output logic [IDX_W-1:0] odd_rd_idx,
    output logic             odd_rd_sel,
    output logic [IDX_W-1:0] wr_idx,
    output logic             even_wr_en,
    output logic             odd_wr_en,
    output logic             count_dec,
    output logic             pred_taken
);

    localparam int PACK_W = 3 * IDX_W + 5;
    localparam logic [IDX_W-1:0] L_IDX = IDX_W'(LINK_IDX);
    localparam logic [IDX_W-1:0] T_IDX = IDX_W'(TARGET_IDX);

    br_kind_e         kind;
    logic [IDX_W-1:0] n_even_rd, n_odd_rd, n_wr;
    logic             n_odd_sel, n_even_we, n_odd_we, n_dec, n_pred;
    logic [PACK_W-1:0] pack_d, pack_q;

    brs_classify #(.INSN_W(INSN_W)) i_classify (
        .insn (insn_in),
        .kind (kind)
    );

    brs_route #(
        .IDX_W      (IDX_W),
        .LINK_IDX   (LINK_IDX),
        .TARGET_IDX (TARGET_IDX)
    ) i_route (
        .valid    (valid_in),
        .kind     (kind),
        .bo2_bit  (insn_in[BIT_BO2]),
        .link_bit (insn_in[BIT_LINK]),
        .hint_bit (insn_in[BIT_HINT]),
        .even_rd  (n_even_rd),
        .odd_rd   (n_odd_rd),
        .odd_sel  (n_odd_sel),
        .wr       (n_wr),
        .even_we  (n_even_we),
        .odd_we   (n_odd_we),
        .dec      (n_dec),
        .pred     (n_pred)
    );

    assign pack_d = {n_even_rd, n_odd_rd, n_odd_sel, n_wr,
                     n_even_we, n_odd_we, n_dec, n_pred};

    brs_hold #(.W(PACK_W), .REGISTERED(OUT_REG)) i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pack_d),
        .q     (pack_q)
    );

    assign {even_rd_idx, odd_rd_idx, odd_rd_sel, wr_idx,
            even_wr_en, odd_wr_en, count_dec, pred_taken} = pack_q;

    generate
        if (OUT_REG) begin : g_chk
            logic past_ok;
            // Purpose: mark cycles whose previous edge was outside reset.
            always_ff @(posedge clk) past_ok <= rst_n;

            // R4: an odd-bank write only happens for a count decrement,
            // and then targets the count index.
            a_r4_odd_write_is_count: assert property (@(posedge clk)
                disable iff (!rst_n)
                odd_wr_en |-> (count_dec && odd_rd_idx == L_IDX && wr_idx == L_IDX));

            // R5: an even-bank write always lands on the link index.
            a_r5_even_write_at_link: assert property (@(posedge clk)
                disable iff (!rst_n)
                even_wr_en |-> (wr_idx == L_IDX));

            // R6: the odd-select source never writes the odd bank.
            a_r6_odd_sel_no_count_write: assert property (@(posedge clk)
                disable iff (!rst_n)
                odd_rd_sel |-> (!odd_wr_en && !count_dec && even_rd_idx == '0));

            // R3: a set bit 23 never yields a decrement.
            a_r3_bo2_blocks_dec: assert property (@(posedge clk)
                disable iff (!rst_n)
                (past_ok && $past(valid_in && insn_in[BIT_BO2])) |-> !count_dec);

            // R9: invalid input gives idle outputs one clock later.
            a_r9_invalid_idle: assert property (@(posedge clk)
                disable iff (!rst_n)
                (past_ok && $past(!valid_in)) |-> (pack_q == '0));

            // R1: an even read is either idle, link or target.
            a_r1_even_read_range: assert property (@(posedge clk)
                disable iff (!rst_n)
                (even_rd_idx == '0 || even_rd_idx == L_IDX || even_rd_idx == T_IDX));
        end
    endgenerate

endmodule

// File: tb/test_brspr_access_decode.sv
module test_brspr_access_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] insn_in = '0;
    logic [2:0]  even_rd_idx, odd_rd_idx, wr_idx;
    logic        odd_rd_sel, even_wr_en, odd_wr_en, count_dec, pred_taken;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    brspr_access_decode i_brspr_access_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_in    (valid_in),
        .insn_in     (insn_in),
        .even_rd_idx (even_rd_idx),
        .odd_rd_idx  (odd_rd_idx),
        .odd_rd_sel  (odd_rd_sel),
        .wr_idx      (wr_idx),
        .even_wr_en  (even_wr_en),
        .odd_wr_en   (odd_wr_en),
        .count_dec   (count_dec),
        .pred_taken  (pred_taken)
    );

    // Expected vector layout: {erd[2:0], ord[2:0], osel, wr[2:0], ewe, owe, dec, pred}
    function automatic logic [13:0] exp_v(input logic [2:0] erd, input logic [2:0] ord,
                                          input logic osel, input logic [2:0] wr,
                                          input logic ewe, input logic owe,
                                          input logic dec, input logic pred);
        return {erd, ord, osel, wr, ewe, owe, dec, pred};
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [9:0] xo,
                                       input logic b23, input logic b15, input logic b0);
        logic [31:0] w;
        w = '0;
        w[31:26] = opc;
        w[10:1]  = xo;
        w[23]    = b23;
        w[15]    = b15;
        w[0]     = b0;
        return w;
    endfunction

    task automatic check(input string req, input logic [13:0] expv);
        logic [13:0] act;
        act = {even_rd_idx, odd_rd_idx, odd_rd_sel, wr_idx,
               even_wr_en, odd_wr_en, count_dec, pred_taken};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, check at the next fall.
    task automatic apply(input logic v, input logic [31:0] w, input string req,
                         input logic [13:0] expv);
        @(negedge clk);
        valid_in = v;
        insn_in  = w;
        @(negedge clk);
        check(req, expv);
    endtask

    task automatic t_reset_state();
        check("R10 reset", '0);
    endtask

    task automatic t_relative();
        // R3 R4 R7: decrement, backward hint gives taken
        apply(1'b1, mk(6'd16, 10'd0, 1'b0, 1'b1, 1'b0), "R4 rel dec",
              exp_v(3'd0, 3'd5, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1));
        // R5 R7: no decrement, link write, forward hint gives not taken
        apply(1'b1, mk(6'd16, 10'd0, 1'b1, 1'b0, 1'b1), "R5 rel link",
              exp_v(3'd0, 3'd0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0));
        // R5 with R4: both writes share index 5 (R1)
        apply(1'b1, mk(6'd16, 10'd0, 1'b0, 1'b0, 1'b1), "R5 rel dec+link",
              exp_v(3'd0, 3'd5, 1'b0, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0));
    endtask

    task automatic t_uncond();
        // R7: always taken; R3: bit 23 clear has no effect
        apply(1'b1, mk(6'd18, 10'd0, 1'b0, 1'b0, 1'b0), "R7 uncond",
              exp_v(3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        apply(1'b1, mk(6'd18, 10'd0, 1'b0, 1'b0, 1'b1), "R5 uncond link",
              exp_v(3'd0, 3'd0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1));
    endtask

    task automatic t_indirect();
        // R6 via link with R3 decrement and R5 link write
        apply(1'b1, mk(6'd19, 10'd16, 1'b0, 1'b1, 1'b1), "R6 via link dec+link",
              exp_v(3'd5, 3'd5, 1'b0, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0));
        // R3: via count never decrements even with bit 23 clear
        apply(1'b1, mk(6'd19, 10'd528, 1'b0, 1'b0, 1'b1), "R3 via count no dec",
              exp_v(3'd0, 3'd5, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0));
        // R6 via target, bit 23 set
        apply(1'b1, mk(6'd19, 10'd560, 1'b1, 1'b0, 1'b0), "R6 via target",
              exp_v(3'd6, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        // R1 R6 via target with decrement
        apply(1'b1, mk(6'd19, 10'd560, 1'b0, 1'b0, 1'b0), "R1 via target dec",
              exp_v(3'd6, 3'd5, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0));
    endtask

    task automatic t_non_branch();
        // R8: other opcode with stray bits set
        apply(1'b1, mk(6'd31, 10'd16, 1'b0, 1'b1, 1'b1), "R8 other opcode", '0);
        // R8 R2: opcode 19 with another extended code
        apply(1'b1, mk(6'd19, 10'd150, 1'b0, 1'b1, 1'b1), "R2 op19 other xo", '0);
        apply(1'b1, mk(6'd17, 10'd0, 1'b0, 1'b1, 1'b1), "R8 opcode 17", '0);
    endtask

    task automatic t_invalid();
        // R9: branch word with valid low
        apply(1'b0, mk(6'd16, 10'd0, 1'b0, 1'b1, 1'b1), "R9 valid low", '0);
    endtask

    task automatic t_mid_reset();
        apply(1'b1, mk(6'd16, 10'd0, 1'b0, 1'b1, 1'b1), "R10 pre reset",
              exp_v(3'd0, 3'd5, 1'b0, 3'd5, 1'b1, 1'b1, 1'b1, 1'b1));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears", '0);
        rst_n = 1'b1;
        valid_in = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_relative();
        t_uncond();
        t_indirect();
        t_non_branch();
        t_invalid();
        t_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule